// File: doc/BRIEF.md
# Fetch Group Former with Static Branch Prediction

This block sits at the front of a multithreaded superscalar pipeline. Each cycle it serves one hardware thread, chosen by a round-robin selector outside the block. It owns one program counter for each thread. It presents the selected thread's counter as the start of a fetch group. The group is a run of consecutive instruction addresses, at most as long as the issue width, and lane i holds address `fetch_pc + i`. Addresses count instructions, not bytes.

A pre-decoder supplies three items for every lane: whether the lane holds a branch, the branch target, and the sign of the branch offset. The block trims the group at the end of the current cache line. It also trims the group just after the first branch that the static rule predicts taken: a backward branch is taken and a forward branch is not. It then works out where the selected thread fetches next.

The next address is written back into that thread's counter only when the thread's fetch buffer has room for a whole group. A redirect from later in the pipe can overwrite any thread's counter at the same clock edge.

Top module: `fbf_fetch_former`

## Requirements
- R1: After reset is released, the counter of every thread equals `BOOT_PC`.
- R2: `fetch_pc` shows the counter of the thread on `sel_tid`. Only that thread's counter advances at a clock edge, apart from the thread named by a redirect.
- R3: `slot_valid` is always a contiguous run of ones that starts at lane 0, with at most `ISSUE_W` lanes set.
- R4: A cache line is an aligned run of `LINE_INSTR` instruction addresses. Its offset is `fetch_pc[$clog2(LINE_INSTR)-1:0]`. A lane whose address lies past the last address of the current line is never valid.
- R5: A lane whose `pd_is_br` bit is 1 is predicted taken when its `pd_back` bit is 1 (backward offset). It is predicted not taken when `pd_back` is 0 (forward offset).
- R6: The first lane within the line that holds a predicted-taken branch is the last valid lane. In that case `pred_taken` is 1 and `next_pc` equals that lane's target, taken from `pd_target[i*AW +: AW]`.
- R7: When no lane within the line holds a predicted-taken branch, `pred_taken` is 0. In that case `next_pc` equals `fetch_pc` plus the number of valid lanes.
- R8: Branch information on lanes past the line end has no effect on `slot_valid`, `next_pc` or `pred_taken`.
- R9: When `fbuf_room[sel_tid]` is 0, `slot_valid` is 0 and `pred_taken` is 0. `next_pc` equals `fetch_pc`, and the selected thread's counter keeps its value.
- R10: When `redir_valid` is 1, the counter of thread `redir_tid` takes the value `redir_pc` at the clock edge. This wins over the fetch update, even when that same thread is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_tid | input | TID_W | Thread served this cycle |
| fbuf_room | input | N_THREADS | Per-thread flag: fetch buffer can take a full group |
| pd_is_br | input | ISSUE_W | Per-lane flag: lane holds a branch |
| pd_back | input | ISSUE_W | Per-lane flag: branch offset is negative |
| pd_target | input | ISSUE_W*AW | Per-lane branch target, lane i at bits i*AW |
| redir_valid | input | 1 | Redirect request |
| redir_tid | input | TID_W | Thread to redirect |
| redir_pc | input | AW | Corrected counter value |
| fetch_pc | output | AW | Address of lane 0 |
| slot_valid | output | ISSUE_W | Valid lanes of the group |
| next_pc | output | AW | Predicted next address for the selected thread |
| pred_taken | output | 1 | Group ended on a predicted-taken branch |

## Verification
The hardest case to reach from the ports is a group that the line edge and a backward branch both want to end. The line edge must win, so a taken branch placed past the line end must be ignored. To build this, the stimulus first redirects a thread to an address with a large line offset. It then selects that thread with a backward branch on a lane beyond the line end, and in a later cycle with two taken branches inside the line. A redirect aimed at the thread that is being fetched in the same cycle is also driven, to show that the redirect wins over the fetch update.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  // Why the current group ended; chooses the source of the next address.
  typedef enum logic [1:0] {
    END_STALL = 2'd0,
    END_SEQ   = 2'd1,
    END_TAKEN = 2'd2
  } fbf_end_e;

endpackage

// File: rtl/fbf_line_clip.sv
module fbf_line_clip #(
  parameter int ISSUE_W    = 4,
  parameter int LINE_INSTR = 8,
  parameter int AW         = 32
) (
  input  logic [AW-1:0]      pc,
  output logic [ISSUE_W-1:0] lane_in_line
);
  localparam int OFS_W = $clog2(LINE_INSTR);
  localparam int REM_W = OFS_W + 1;

  logic [REM_W-1:0] remain;

  // Number of addresses left in the line, counted from pc.
  assign remain = REM_W'(LINE_INSTR) - {1'b0, pc[OFS_W-1:0]};

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
    assign lane_in_line[i] = (REM_W'(i) < remain);
  end

endmodule

// File: rtl/fbf_branch_scan.sv
module fbf_branch_scan #(
  parameter int ISSUE_W = 4,
  parameter int AW      = 32
) (
  input  logic [ISSUE_W-1:0]    lane_ok,
  input  logic [ISSUE_W-1:0]    is_br,
  input  logic [ISSUE_W-1:0]    back,
  input  logic [ISSUE_W*AW-1:0] target,
  output logic [ISSUE_W-1:0]    keep,
  output logic                  hit,
  output logic [AW-1:0]         hit_target
);
  logic [ISSUE_W-1:0] take;

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_pred
    // Backward branches are taken, forward branches fall through.
    assign take[i] = lane_ok[i] & is_br[i] & back[i];
  end

  always_comb begin
    logic blocked;
    blocked    = 1'b0;
    keep       = '0;
    hit        = 1'b0;
    hit_target = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (!blocked) begin
        keep[i] = 1'b1;
        if (take[i]) begin
          blocked    = 1'b1;
          hit        = 1'b1;
          hit_target = target[i*AW +: AW];
        end
      end
    end
  end

endmodule

// File: rtl/fbf_pc_bank.sv
module fbf_pc_bank #(
  parameter int          N_THREADS = 4,
  parameter int          AW        = 32,
  parameter logic [31:0] BOOT_PC   = 32'h0,
  parameter int          TID_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [TID_W-1:0] upd_tid,
  input  logic [AW-1:0]    upd_pc,
  input  logic             redir_en,
  input  logic [TID_W-1:0] redir_tid,
  input  logic [AW-1:0]    redir_pc,
  input  logic [TID_W-1:0] rd_tid,
  output logic [AW-1:0]    rd_pc
);
  logic [N_THREADS*AW-1:0] pc_flat;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;
    logic          pc_en;
    logic          hit_upd;
    logic          hit_redir;

    assign hit_upd   = upd_en   && (upd_tid   == TID_W'(t));
    assign hit_redir = redir_en && (redir_tid == TID_W'(t));

    always_comb begin
      pc_d  = pc_q;
      pc_en = hit_upd | hit_redir;
      if (hit_upd)   pc_d = upd_pc;
      if (hit_redir) pc_d = redir_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q <= AW'(BOOT_PC);
      else if (pc_en) pc_q <= pc_d;
    end

    assign pc_flat[t*AW +: AW] = pc_q;
  end

  assign rd_pc = pc_flat[rd_tid*AW +: AW];

endmodule

// File: rtl/fbf_fetch_former.sv
module fbf_fetch_former
  import fbf_pkg::*;
#(
  parameter int          ISSUE_W    = 4,
  parameter int          LINE_INSTR = 8,
  parameter int          N_THREADS  = 4,
  parameter int          AW         = 32,
  parameter logic [31:0] BOOT_PC    = 32'h0,
  parameter int          TID_W      = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TID_W-1:0]      sel_tid,
  input  logic [N_THREADS-1:0]  fbuf_room,
  input  logic [ISSUE_W-1:0]    pd_is_br,
  input  logic [ISSUE_W-1:0]    pd_back,
  input  logic [ISSUE_W*AW-1:0] pd_target,
  input  logic                  redir_valid,
  input  logic [TID_W-1:0]      redir_tid,
  input  logic [AW-1:0]         redir_pc,
  output logic [AW-1:0]         fetch_pc,
  output logic [ISSUE_W-1:0]    slot_valid,
  output logic [AW-1:0]         next_pc,
  output logic                  pred_taken
);
  localparam int CNT_W = $clog2(ISSUE_W + 1);

  logic [ISSUE_W-1:0] lane_in_line;
  logic [ISSUE_W-1:0] keep;
  logic               br_hit;
  logic [AW-1:0]      br_target;
  logic               room;
  logic [CNT_W-1:0]   n_valid;
  fbf_end_e           end_cause;

  fbf_pc_bank #(
    .N_THREADS(N_THREADS), .AW(AW), .BOOT_PC(BOOT_PC), .TID_W(TID_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (room),
    .upd_tid  (sel_tid),
    .upd_pc   (next_pc),
    .redir_en (redir_valid),
    .redir_tid(redir_tid),
    .redir_pc (redir_pc),
    .rd_tid   (sel_tid),
    .rd_pc    (fetch_pc)
  );

  fbf_line_clip #(
    .ISSUE_W(ISSUE_W), .LINE_INSTR(LINE_INSTR), .AW(AW)
  ) u_clip (
    .pc          (fetch_pc),
    .lane_in_line(lane_in_line)
  );

  fbf_branch_scan #(
    .ISSUE_W(ISSUE_W), .AW(AW)
  ) u_scan (
    .lane_ok   (lane_in_line),
    .is_br     (pd_is_br),
    .back      (pd_back),
    .target    (pd_target),
    .keep      (keep),
    .hit       (br_hit),
    .hit_target(br_target)
  );

  assign room = fbuf_room[sel_tid];

  always_comb begin
    if (!room)       end_cause = END_STALL;
    else if (br_hit) end_cause = END_TAKEN;
    else             end_cause = END_SEQ;
  end

  assign slot_valid = room ? (lane_in_line & keep) : '0;

  always_comb begin
    n_valid = '0;
    for (int i = 0; i < ISSUE_W; i++) n_valid = n_valid + CNT_W'(slot_valid[i]);
  end

  always_comb begin
    unique case (end_cause)
      END_TAKEN: next_pc = br_target;
      END_SEQ:   next_pc = fetch_pc + AW'(n_valid);
      default:   next_pc = fetch_pc;
    endcase
  end

  assign pred_taken = (end_cause == END_TAKEN);

endmodule

// File: rtl/fbf_fetch_former_chk.sv
module fbf_fetch_former_chk #(
  parameter int ISSUE_W    = 4,
  parameter int LINE_INSTR = 8,
  parameter int N_THREADS  = 4,
  parameter int AW         = 32,
  parameter int TID_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [TID_W-1:0]      sel_tid,
  input logic [N_THREADS-1:0]  fbuf_room,
  input logic                  redir_valid,
  input logic [TID_W-1:0]      redir_tid,
  input logic [AW-1:0]         redir_pc,
  input logic [AW-1:0]         fetch_pc,
  input logic [ISSUE_W-1:0]    slot_valid,
  input logic [AW-1:0]         next_pc,
  input logic                  pred_taken
);
  localparam int OFS_W = $clog2(LINE_INSTR);

  logic [ISSUE_W:0] mask_plus;
  logic [OFS_W:0]   line_left;

  assign mask_plus = {1'b0, slot_valid} + 1'b1;
  assign line_left = (OFS_W+1)'(LINE_INSTR) - {1'b0, fetch_pc[OFS_W-1:0]};

  // R3
  prefix_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_plus) == 1);

  // R4
  line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_valid) <= line_left);

  // R9
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fbuf_room[sel_tid] |-> (slot_valid == '0) && !pred_taken && (next_pc == fetch_pc));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && redir_tid == sel_tid)
    |=> (sel_tid != $past(sel_tid)) || (fetch_pc == $past(next_pc)));

  // R10
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (sel_tid != $past(redir_tid)) || (fetch_pc == $past(redir_pc)));

endmodule

bind fbf_fetch_former fbf_fetch_former_chk #(
  .ISSUE_W(ISSUE_W), .LINE_INSTR(LINE_INSTR), .N_THREADS(N_THREADS),
  .AW(AW), .TID_W(TID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_tid    (sel_tid),
  .fbuf_room  (fbuf_room),
  .redir_valid(redir_valid),
  .redir_tid  (redir_tid),
  .redir_pc   (redir_pc),
  .fetch_pc   (fetch_pc),
  .slot_valid (slot_valid),
  .next_pc    (next_pc),
  .pred_taken (pred_taken)
);

// File: tb/fbf_fetch_former_bench.sv
`timescale 1ns/1ps
module fbf_fetch_former_bench;
  localparam int W  = 4;
  localparam int LN = 8;
  localparam int NT = 4;
  localparam int AW = 32;

  typedef struct {
    string         tag;
    logic [AW-1:0] fpc;
    logic [W-1:0]  mask;
    logic [AW-1:0] nxt;
    logic          tkn;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      sel_tid = '0;
  logic [NT-1:0]   fbuf_room = '0;
  logic [W-1:0]    pd_is_br = '0;
  logic [W-1:0]    pd_back = '0;
  logic [W*AW-1:0] pd_target = '0;
  logic            redir_valid = 1'b0;
  logic [1:0]      redir_tid = '0;
  logic [AW-1:0]   redir_pc = '0;
  logic [AW-1:0]   fetch_pc;
  logic [W-1:0]    slot_valid;
  logic [AW-1:0]   next_pc;
  logic            pred_taken;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [AW-1:0] pc_m [NT];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fbf_fetch_former u_fbf_fetch_former (
    .clk(clk), .rst_n(rst_n), .sel_tid(sel_tid), .fbuf_room(fbuf_room),
    .pd_is_br(pd_is_br), .pd_back(pd_back), .pd_target(pd_target),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .fetch_pc(fetch_pc), .slot_valid(slot_valid), .next_pc(next_pc),
    .pred_taken(pred_taken)
  );

  task automatic cmp(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, predicts the outputs, updates the model.
  task automatic step(string tag, int sel, bit room, logic [W-1:0] isbr,
                      logic [W-1:0] back, logic [AW-1:0] t0, logic [AW-1:0] t1,
                      logic [AW-1:0] t2, logic [AW-1:0] t3,
                      bit rv = 0, int rt = 0, logic [AW-1:0] rp = '0);
    exp_t e;
    logic [AW-1:0] tg [W];
    int rem;
    int cnt;
    bit stop;
    @(negedge clk);
    tg[0] = t0; tg[1] = t1; tg[2] = t2; tg[3] = t3;
    sel_tid     = 2'(sel);
    fbuf_room   = '0;
    fbuf_room[sel] = room;
    pd_is_br    = isbr;
    pd_back     = back;
    pd_target   = {t3, t2, t1, t0};
    redir_valid = rv;
    redir_tid   = 2'(rt);
    redir_pc    = rp;
    e.tag  = tag;
    e.fpc  = pc_m[sel];
    e.mask = '0;
    e.tkn  = 1'b0;
    rem    = LN - int'(pc_m[sel] % LN);
    cnt    = 0;
    stop   = 1'b0;
    e.nxt  = pc_m[sel];
    for (int i = 0; i < W; i++) begin
      if (i < rem && !stop) begin
        e.mask[i] = 1'b1;
        cnt++;
        if (isbr[i] && back[i]) begin
          stop  = 1'b1;
          e.tkn = 1'b1;
          e.nxt = tg[i];
        end
      end
    end
    if (!e.tkn) e.nxt = pc_m[sel] + AW'(cnt);
    if (!room) begin
      e.mask = '0;
      e.tkn  = 1'b0;
      e.nxt  = pc_m[sel];
    end
    q.push_back(e);
    pc_m[sel] = e.nxt;
    if (rv) pc_m[rt] = rp;
  endtask

  // Monitor: compares outputs well before the next rising edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "fetch_pc",   fetch_pc,        e.fpc);
        cmp(e.tag, "slot_valid", AW'(slot_valid), AW'(e.mask));
        cmp(e.tag, "next_pc",    next_pc,         e.nxt);
        cmp(e.tag, "pred_taken", AW'(pred_taken), AW'(e.tkn));
      end
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) pc_m[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every thread starts at the boot address (stalled, so nothing moves)
    for (int t = 0; t < NT; t++) step("R1 R9", t, 0, '0, '0, 0, 0, 0, 0);
    // R3 R7: full group from line start, then group ending exactly on the line edge (R4)
    step("R3 R7", 0, 1, '0, '0, 0, 0, 0, 0);
    step("R4 R7", 0, 1, '0, '0, 0, 0, 0, 0);
    // R10: redirect thread 1 while thread 0 stalls (R9)
    step("R9 R10", 0, 0, 4'hF, 4'hF, 32'h50, 32'h50, 32'h50, 32'h50, 1, 1, 32'h106);
    // R4: offset 6 leaves two lanes
    step("R4 R10", 1, 1, '0, '0, 0, 0, 0, 0);
    // R2: thread 0 kept its counter across the other threads' cycles
    step("R2", 0, 1, '0, '0, 0, 0, 0, 0);
    // R5 R6: backward branch on lane 1
    step("R5 R6", 2, 1, 4'b0010, 4'b0010, 0, 32'h40, 0, 0);
    // R5: forward branch on lane 0 is not taken
    step("R5 R7", 2, 1, 4'b0001, 4'b0000, 32'h90, 0, 0, 0);
    // R8: thread 3 redirected to offset 5, taken branch on lane 3 lies past the edge
    step("R10", 0, 0, '0, '0, 0, 0, 0, 0, 1, 3, 32'h1D);
    step("R8", 3, 1, 4'b1000, 4'b1000, 0, 0, 0, 32'h777);
    // R6: two taken branches, the first one wins
    step("R6", 3, 1, 4'b0101, 4'b0101, 32'h200, 0, 32'h300, 0);
    // R10: redirect to the selected thread beats its own fetch update
    step("R10", 3, 1, 4'b0001, 4'b0001, 32'h400, 0, 0, 0, 1, 3, 32'h333);
    step("R10 R4", 3, 1, '0, '0, 0, 0, 0, 0);
    // R9: no room, the counter holds
    step("R9", 2, 0, 4'b0001, 4'b0001, 32'h10, 0, 0, 0);
    step("R9 R2", 2, 1, '0, '0, 0, 0, 0, 0);
    step("R2 R3", 1, 1, '0, '0, 0, 0, 0, 0);
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule